// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers interrupt requests from a set of devices and offers at most one of them per instruction boundary to a small processor core. Each device owns a latched pending bit, an enable bit and a programmable priority. A global enable flag gates every maskable source. A separate non-maskable line is accepted whatever the enables or the current level are.

The core reports each instruction boundary together with the address of the next instruction. When a request wins, the block emits a one-cycle accept pulse. With the pulse it gives the vector index, the handler start address taken from a writable vector table, and the captured resume address. It also raises the current processor priority level to the winner's priority. The level in force before entry is pushed onto a four-deep saved-level stack, and a return strobe from the core pops it. Only sources with a strictly higher priority can therefore nest inside a running handler. A configuration write port loads the vector table, the device priorities, the device enables and the global enable.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While the global enable flag is 0, no maskable device is accepted. Its pending bit is kept, and the device is accepted once the flag is 1.
- R2: A device whose enable bit is 0 is never accepted. Its pending bit survives, and the device is accepted after its enable is set to 1.
- R3: A one-cycle pulse on `dev_req_i[i]` sets device i's pending bit. The bit stays set until that device is accepted, and acceptance clears it. A device is not accepted a second time without a new pulse.
- R4: A maskable device is accepted only if its priority is strictly greater than `cur_level_o`. Requests of equal or lower priority stay pending.
- R5: Acceptance happens only in a cycle where `boundary_i` is 1. `accept_o` is 1 for exactly the one cycle after that boundary, and is 0 when no new acceptance occurs.
- R6: On acceptance of device i, `cur_level_o` becomes device i's priority in the same cycle that `accept_o` is 1.
- R7: While `accept_o` is 1, `vec_idx_o` equals the accepted device index and `handler_pc_o` equals the vector table entry at that index. Both outputs hold their values between acceptances.
- R8: While `accept_o` is 1, `saved_pc_o` equals the `next_pc_i` value present at the accepted boundary.
- R9: A pulse on `nmi_i` sets a non-maskable pending flag. This flag is accepted at the next boundary regardless of the global enable, the device enables and the current level, including a level already at maximum. It uses index N_DEV and table entry N_DEV, and sets `cur_level_o` to all ones.
- R10: Among eligible sources, the non-maskable one wins first. After it comes the highest device priority, and among equal priorities the lowest device index.
- R11: A cycle with `ret_i` at 1 restores `cur_level_o` to the level saved by the most recent acceptance, or to 0 when nothing is saved. No acceptance takes place in that cycle.
- R12: The saved-level stack holds 4 levels. A winning request that meets a full stack is not accepted and keeps its pending bit, the level is unchanged, and `overflow_o` is 1 for exactly that one cycle.
- R13: A write with `wr_en_i` at 1 acts according to `wr_sel_i`: 0 writes vector entry `wr_idx_i`, 1 writes the low bits of device `wr_idx_i`'s priority, 2 writes device `wr_idx_i`'s enable from `wr_data_i[0]`, and 3 writes the global enable from `wr_data_i[0]`. The write takes effect from the next cycle. Reset clears the level, the global enable, the enables, the priorities, the vector entries and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | N_DEV | Per-device request pulses |
| nmi_i | input | 1 | Non-maskable request pulse |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| ret_i | input | 1 | Return-from-handler strobe |
| next_pc_i | input | ADDR_W | Address of the next instruction at the boundary |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Configuration target: 0 vector, 1 priority, 2 enable, 3 global enable |
| wr_idx_i | input | IDX_W | Entry or device index for the write |
| wr_data_i | input | ADDR_W | Write data |
| accept_o | output | 1 | One-cycle acceptance pulse |
| vec_idx_o | output | IDX_W | Accepted source index (N_DEV for the non-maskable line) |
| handler_pc_o | output | ADDR_W | Handler start address from the vector table |
| saved_pc_o | output | ADDR_W | Captured resume address |
| cur_level_o | output | PRIO_W | Current processor priority level |
| overflow_o | output | 1 | Acceptance suppressed because the saved-level stack was full |

## Verification
The bench builds the controller with six devices, 3-bit priorities, 12-bit addresses and a stack depth of 4. With 3-bit priorities, a chain of five handlers at strictly rising levels 1, 2, 3, 5 and 6 fits below the non-maskable level of 7. The fifth entry meets a full stack, so overflow suppression, keeping of the pending bit, and acceptance after one return are all reached in a short run. Six devices leave room for equal-priority ties, a disabled device and a lower-priority waiter at the same time. A non-maskable entry nested on top of another non-maskable entry exercises the bypass at maximum level.

// File: rtl/nic_pkg.sv
package nic_pkg;

    // Configuration write targets selected by wr_sel_i
    typedef enum logic [1:0] {
        CFG_VEC  = 2'd0,
        CFG_PRIO = 2'd1,
        CFG_EN   = 2'd2,
        CFG_GIE  = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
    parameter int N_DEV  = 8,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [1:0]                     wr_sel_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [ADDR_W-1:0]              wr_data_i,
    output logic [N_DEV:0][ADDR_W-1:0]     vec_o,
    output logic [N_DEV-1:0][PRIO_W-1:0]   prio_o,
    output logic [N_DEV-1:0]               en_o,
    output logic                           gie_o
);
    import nic_pkg::*;

    typedef struct packed {
        logic [N_DEV:0][ADDR_W-1:0]   vec;
        logic [N_DEV-1:0][PRIO_W-1:0] prio;
        logic [N_DEV-1:0]             en;
        logic                         gie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            unique case (cfg_sel_e'(wr_sel_i))
                CFG_VEC: begin
                    for (int i = 0; i <= N_DEV; i++) begin
                        if (wr_idx_i == IDX_W'(i)) cfg_d.vec[i] = wr_data_i;
                    end
                end
                CFG_PRIO: begin
                    for (int i = 0; i < N_DEV; i++) begin
                        if (wr_idx_i == IDX_W'(i)) cfg_d.prio[i] = wr_data_i[PRIO_W-1:0];
                    end
                end
                CFG_EN: begin
                    for (int i = 0; i < N_DEV; i++) begin
                        if (wr_idx_i == IDX_W'(i)) cfg_d.en[i] = wr_data_i[0];
                    end
                end
                CFG_GIE: cfg_d.gie = wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign vec_o  = cfg_q.vec;
    assign prio_o = cfg_q.prio;
    assign en_o   = cfg_q.en;
    assign gie_o  = cfg_q.gie;

    // The global enable only moves on a write aimed at it
    AST_GIE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gie_o) |-> $past(wr_en_i) && ($past(wr_sel_i) == 2'd3)); // R13

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int N_DEV  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 4
) (
    input  logic [N_DEV-1:0]             pend_i,
    input  logic                         nmi_pend_i,
    input  logic [N_DEV-1:0]             en_i,
    input  logic [N_DEV-1:0][PRIO_W-1:0] prio_i,
    input  logic                         gie_i,
    input  logic [PRIO_W-1:0]            level_i,
    output logic                         hit_o,
    output logic                         nmi_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic [PRIO_W-1:0]            prio_o
);
    localparam logic [IDX_W-1:0]  NMI_IDX = IDX_W'(N_DEV);
    localparam logic [PRIO_W-1:0] TOP_LVL = '1;

    logic [N_DEV-1:0] elig;

    // Per-device eligibility: pending, enabled, globally enabled, above level
    for (genvar g = 0; g < N_DEV; g++) begin : g_elig
        assign elig[g] = pend_i[g] && en_i[g] && gie_i && (prio_i[g] > level_i);
    end

    always_comb begin
        hit_o  = 1'b0;
        nmi_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        if (nmi_pend_i) begin
            hit_o  = 1'b1;
            nmi_o  = 1'b1;
            idx_o  = NMI_IDX;
            prio_o = TOP_LVL;
        end else begin
            // Downward scan with >= leaves the lowest index among equals
            for (int i = N_DEV - 1; i >= 0; i--) begin
                if (elig[i] && (!hit_o || prio_i[i] >= prio_o)) begin
                    hit_o  = 1'b1;
                    idx_o  = IDX_W'(i);
                    prio_o = prio_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_val_i,
    output logic [PRIO_W-1:0] top_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    assign full_o  = (stk_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (stk_q.cnt == '0);
    assign top_o   = empty_o ? '0 : stk_q.mem[PTR_W'(stk_q.cnt - 1'b1)];

    always_comb begin
        stk_d = stk_q;
        if (push_i && !full_o) begin
            stk_d.mem[PTR_W'(stk_q.cnt)] = push_val_i;
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop_i && !empty_o) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stk_q <= '0;
        else         stk_q <= stk_d;
    end

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o); // R12
    AST_PUSH_POP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(push_i && pop_i)); // R11

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N_DEV       = 8,
    parameter int PRIO_W      = 3,
    parameter int ADDR_W      = 16,
    parameter int STACK_DEPTH = 4,
    localparam int IDX_W      = $clog2(N_DEV + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_DEV-1:0]   dev_req_i,
    input  logic               nmi_i,
    input  logic               boundary_i,
    input  logic               ret_i,
    input  logic [ADDR_W-1:0]  next_pc_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [ADDR_W-1:0]  wr_data_i,
    output logic               accept_o,
    output logic [IDX_W-1:0]   vec_idx_o,
    output logic [ADDR_W-1:0]  handler_pc_o,
    output logic [ADDR_W-1:0]  saved_pc_o,
    output logic [PRIO_W-1:0]  cur_level_o,
    output logic               overflow_o
);
    localparam logic [IDX_W-1:0]  NMI_IDX = IDX_W'(N_DEV);
    localparam logic [PRIO_W-1:0] TOP_LVL = '1;

    typedef struct packed {
        logic [N_DEV-1:0]  pend;
        logic              nmi_pend;
        logic [PRIO_W-1:0] level;
        logic              acc;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] hpc;
        logic [ADDR_W-1:0] spc;
        logic              ovf;
    } st_t;

    st_t st_d, st_q;

    logic [N_DEV:0][ADDR_W-1:0]   cfg_vec;
    logic [N_DEV-1:0][PRIO_W-1:0] cfg_prio;
    logic [N_DEV-1:0]             cfg_en;
    logic                         cfg_gie;

    logic              arb_hit, arb_nmi;
    logic [IDX_W-1:0]  arb_idx;
    logic [PRIO_W-1:0] arb_prio;

    logic              take, do_acc;
    logic              stk_pop;
    logic [PRIO_W-1:0] stk_top;
    logic              stk_full, stk_empty;

    nic_cfg_regs #(
        .N_DEV (N_DEV),
        .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_idx_i (wr_idx_i),
        .wr_data_i(wr_data_i),
        .vec_o    (cfg_vec),
        .prio_o   (cfg_prio),
        .en_o     (cfg_en),
        .gie_o    (cfg_gie)
    );

    nic_arbiter #(
        .N_DEV (N_DEV),
        .PRIO_W(PRIO_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .pend_i    (st_q.pend),
        .nmi_pend_i(st_q.nmi_pend),
        .en_i      (cfg_en),
        .prio_i    (cfg_prio),
        .gie_i     (cfg_gie),
        .level_i   (st_q.level),
        .hit_o     (arb_hit),
        .nmi_o     (arb_nmi),
        .idx_o     (arb_idx),
        .prio_o    (arb_prio)
    );

    // A return strobe owns its cycle; acceptance waits for the next boundary
    assign take    = arb_hit && boundary_i && !ret_i;
    assign do_acc  = take && !stk_full;
    assign stk_pop = ret_i;

    nic_level_stack #(
        .DEPTH (STACK_DEPTH),
        .PRIO_W(PRIO_W)
    ) u_stk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (do_acc),
        .pop_i     (stk_pop),
        .push_val_i(st_q.level),
        .top_o     (stk_top),
        .full_o    (stk_full),
        .empty_o   (stk_empty)
    );

    always_comb begin
        st_d     = st_q;
        st_d.acc = 1'b0;
        st_d.ovf = take && stk_full;

        if (do_acc) begin
            st_d.acc   = 1'b1;
            st_d.idx   = arb_idx;
            st_d.hpc   = cfg_vec[arb_idx];
            st_d.spc   = next_pc_i;
            st_d.level = arb_prio;
            if (arb_nmi) begin
                st_d.nmi_pend = 1'b0;
            end else begin
                for (int i = 0; i < N_DEV; i++) begin
                    if (arb_idx == IDX_W'(i)) st_d.pend[i] = 1'b0;
                end
            end
        end else if (ret_i) begin
            st_d.level = stk_empty ? '0 : stk_top;
        end

        // New pulses land after clearing, so a fresh request is never lost
        st_d.pend     = st_d.pend | dev_req_i;
        st_d.nmi_pend = st_d.nmi_pend | nmi_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign accept_o     = st_q.acc;
    assign vec_idx_o    = st_q.idx;
    assign handler_pc_o = st_q.hpc;
    assign saved_pc_o   = st_q.spc;
    assign cur_level_o  = st_q.level;
    assign overflow_o   = st_q.ovf;

    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> $past(boundary_i)); // R5
    AST_GIE_GATES_MASKABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && vec_idx_o != NMI_IDX) |-> $past(cfg_gie)); // R1
    AST_LEVEL_STRICT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && vec_idx_o != NMI_IDX) |-> (cur_level_o > $past(cur_level_o))); // R4
    AST_RETURN_BLOCKS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ret_i) |-> !accept_o); // R11
    AST_NMI_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && vec_idx_o == NMI_IDX) |-> (cur_level_o == TOP_LVL)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> !accept_o && $stable(cur_level_o)); // R12

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    localparam int N  = 6;
    localparam int PW = 3;
    localparam int AW = 12;
    localparam int D  = 4;
    localparam int IW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          b_bnd = 1'b0, b_ret = 1'b0, b_nmi = 1'b0, b_wr = 1'b0;
    logic [N-1:0]  b_req = '0;
    logic [AW-1:0] b_pc = '0, b_wdata = '0;
    logic [1:0]    b_wsel = '0;
    logic [IW-1:0] b_widx = '0;

    logic          acc, ovf;
    logic [IW-1:0] idx;
    logic [AW-1:0] hpc, spc;
    logic [PW-1:0] lvl;

    nest_irq_ctrl #(.N_DEV(N), .PRIO_W(PW), .ADDR_W(AW), .STACK_DEPTH(D)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .dev_req_i(b_req), .nmi_i(b_nmi),
        .boundary_i(b_bnd), .ret_i(b_ret), .next_pc_i(b_pc),
        .wr_en_i(b_wr), .wr_sel_i(b_wsel), .wr_idx_i(b_widx), .wr_data_i(b_wdata),
        .accept_o(acc), .vec_idx_o(idx), .handler_pc_o(hpc), .saved_pc_o(spc),
        .cur_level_o(lvl), .overflow_o(ovf)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_prio[N], m_en[N], m_pend[N], m_vec[N+1];
    int m_gie, m_lvl, m_nmi;
    int m_stk[$];
    int e_acc, e_idx, e_hpc, e_spc, e_ovf;
    int sel, best;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; end
            for (int i = 0; i <= N; i++) m_vec[i] = 0;
            m_gie = 0; m_lvl = 0; m_nmi = 0; m_stk.delete();
            e_acc = 0; e_idx = 0; e_hpc = 0; e_spc = 0; e_ovf = 0;
        end else begin
            e_acc = 0; e_ovf = 0; sel = -1; best = -1;
            if (b_bnd && !b_ret) begin
                if (m_nmi != 0) sel = N;
                else if (m_gie != 0) begin
                    for (int i = 0; i < N; i++)
                        if (m_pend[i] != 0 && m_en[i] != 0 && m_prio[i] > m_lvl && m_prio[i] > best) begin
                            best = m_prio[i]; sel = i;
                        end
                end
            end
            if (sel >= 0) begin
                if (m_stk.size() == D) e_ovf = 1;
                else begin
                    e_acc = 1; e_idx = sel; e_hpc = m_vec[sel]; e_spc = int'(b_pc);
                    m_stk.push_back(m_lvl);
                    if (sel == N) begin m_lvl = 7; m_nmi = 0; end
                    else begin m_lvl = m_prio[sel]; m_pend[sel] = 0; end
                end
            end
            if (b_ret) m_lvl = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
            for (int i = 0; i < N; i++) if (b_req[i]) m_pend[i] = 1;
            if (b_nmi) m_nmi = 1;
            if (b_wr) begin
                case (b_wsel)
                    2'd0: if (int'(b_widx) <= N) m_vec[b_widx] = int'(b_wdata);
                    2'd1: if (int'(b_widx) < N) m_prio[b_widx] = int'(b_wdata) & 7;
                    2'd2: if (int'(b_widx) < N) m_en[b_widx] = int'(b_wdata) & 1;
                    default: m_gie = int'(b_wdata) & 1;
                endcase
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(acc) == e_acc, "R5 accept pulse", int'(acc), e_acc);
            chk(int'(ovf) == e_ovf, "R12 overflow", int'(ovf), e_ovf);
            chk(int'(lvl) == m_lvl, "R6 level", int'(lvl), m_lvl);
            chk(int'(idx) == e_idx, "R7 index", int'(idx), e_idx);
            chk(int'(hpc) == e_hpc, "R7 handler", int'(hpc), e_hpc);
            chk(int'(spc) == e_spc, "R8 saved pc", int'(spc), e_spc);
        end
    end

    int pc_ctr = 'h40;
    int last_pc;

    task automatic cyc(input bit bnd, input bit ret, input logic [N-1:0] req, input bit nmi);
        pc_ctr += 4;
        last_pc = pc_ctr & 'hFFF;
        b_bnd = bnd; b_ret = ret; b_req = req; b_nmi = nmi; b_pc = AW'(pc_ctr);
        @(negedge clk);
        b_bnd = 1'b0; b_ret = 1'b0; b_req = '0; b_nmi = 1'b0;
    endtask

    task automatic wr(input int s, input int i, input int dat);
        b_wr = 1'b1; b_wsel = 2'(s); b_widx = IW'(i); b_wdata = AW'(dat);
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic expect_acc(input string tag, input int e_i, input int e_l);
        chk(acc == 1'b1, tag, int'(acc), 1);
        chk(int'(idx) == e_i, tag, int'(idx), e_i);
        chk(int'(lvl) == e_l, tag, int'(lvl), e_l);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(acc == 1'b0 && lvl == '0, "R13 reset state", int'(lvl), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Configuration: priorities 2,2,5,1,3,6; vectors 0x100 + 0x10*i; NMI entry 0xF00
        wr(1, 0, 2); wr(1, 1, 2); wr(1, 2, 5); wr(1, 3, 1); wr(1, 4, 3); wr(1, 5, 6);
        for (int i = 0; i < N; i++) begin wr(0, i, 'h100 + 'h10 * i); wr(2, i, 1); end
        wr(0, N, 'hF00);

        // R1: global enable still 0
        cyc(0, 0, 6'b000001, 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b0, "R1 masked by global enable", int'(acc), 0);
        wr(3, 0, 1);
        cyc(1, 0, '0, 0);
        expect_acc("R1 accepted after enable", 0, 2);
        chk(hpc == 12'h100, "R7 handler entry 0", int'(hpc), 'h100);
        chk(int'(spc) == last_pc, "R8 resume address", int'(spc), last_pc);

        // R5 pulse length, R3 cleared pending
        cyc(0, 0, '0, 0);
        chk(acc == 1'b0, "R5 single-cycle pulse", int'(acc), 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b0, "R3 pending cleared by acceptance", int'(acc), 0);

        // R4: equal and lower priority held
        cyc(0, 0, 6'b001010, 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b0, "R4 equal or lower held off", int'(acc), 0);
        cyc(0, 0, 6'b000100, 0);
        cyc(0, 0, '0, 0);
        chk(acc == 1'b0, "R5 no boundary no acceptance", int'(acc), 0);
        cyc(1, 0, '0, 0);
        expect_acc("R4 strictly higher nests", 2, 5);

        // R11: return blocks acceptance and restores levels
        cyc(1, 1, '0, 0);
        chk(acc == 1'b0 && lvl == 3'd2, "R11 return restores level", int'(lvl), 2);
        cyc(1, 1, '0, 0);
        chk(acc == 1'b0 && lvl == 3'd0, "R11 return to base", int'(lvl), 0);
        cyc(1, 0, '0, 0);
        expect_acc("R10 higher priority first", 1, 2);
        cyc(0, 1, '0, 0);
        cyc(1, 0, '0, 0);
        expect_acc("R10 lower priority later", 3, 1);
        cyc(0, 1, '0, 0);

        // R10: tie broken by lowest index
        cyc(0, 0, 6'b001011, 0);
        cyc(1, 0, '0, 0);
        expect_acc("R10 tie lowest index", 0, 2);
        cyc(0, 1, '0, 0);
        cyc(1, 0, '0, 0);
        expect_acc("R10 tie second", 1, 2);
        cyc(0, 1, '0, 0);
        cyc(1, 0, '0, 0);
        expect_acc("R10 remaining low", 3, 1);
        cyc(0, 1, '0, 0);

        // R2: device enable
        wr(2, 4, 0);
        cyc(0, 0, 6'b010000, 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b0, "R2 disabled device ignored", int'(acc), 0);
        wr(2, 4, 1);
        cyc(1, 0, '0, 0);
        expect_acc("R2 accepted after enable", 4, 3);
        cyc(0, 1, '0, 0);

        // R9: non-maskable bypass, nested at top level
        wr(3, 0, 0);
        cyc(0, 0, '0, 1);
        cyc(1, 0, '0, 0);
        expect_acc("R9 non-maskable accepted", N, 7);
        chk(hpc == 12'hF00, "R9 non-maskable handler", int'(hpc), 'hF00);
        cyc(0, 0, '0, 1);
        cyc(1, 0, '0, 0);
        expect_acc("R9 nested at top level", N, 7);
        cyc(0, 1, '0, 0);
        cyc(0, 1, '0, 0);
        chk(lvl == 3'd0, "R11 levels unwound", int'(lvl), 0);
        wr(3, 0, 1);

        // R12: stack overflow
        cyc(0, 0, 6'b001000, 0); cyc(1, 0, '0, 0);
        cyc(0, 0, 6'b000001, 0); cyc(1, 0, '0, 0);
        cyc(0, 0, 6'b010000, 0); cyc(1, 0, '0, 0);
        cyc(0, 0, 6'b000100, 0); cyc(1, 0, '0, 0);
        expect_acc("R12 fourth nesting", 2, 5);
        cyc(0, 0, 6'b100000, 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b0 && ovf == 1'b1, "R12 suppressed on full stack", int'(ovf), 1);
        chk(lvl == 3'd5, "R12 level unchanged", int'(lvl), 5);
        cyc(0, 0, '0, 0);
        chk(ovf == 1'b0, "R12 overflow single cycle", int'(ovf), 0);
        cyc(0, 1, '0, 0);
        chk(lvl == 3'd3, "R11 pop after overflow", int'(lvl), 3);
        cyc(1, 0, '0, 0);
        expect_acc("R12 pending kept and accepted", 5, 6);
        for (int k = 0; k < 5; k++) cyc(0, 1, '0, 0);
        cyc(0, 1, '0, 0);
        chk(lvl == 3'd0, "R11 return on empty stack", int'(lvl), 0);

        // R13: vector rewrite visible on next acceptance
        wr(0, 3, 'h345);
        cyc(0, 0, 6'b001000, 0);
        cyc(1, 0, '0, 0);
        chk(acc == 1'b1 && hpc == 12'h345, "R13 vector write", int'(hpc), 'h345);
        cyc(0, 1, '0, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule